// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. Characters written through a simple strobe interface are queued in a small FIFO. A shifter takes them one at a time and frames each one on the line: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. All bit timing comes from a sixteen-times bit-rate enable pulse that an external rate generator supplies.

The character length, the parity mode and the stop length are format inputs. The shifter samples them when it loads a character, so a change takes effect at the next character. A break input forces the line low for as long as it is held. FIFO-empty, transmitter-empty and a fill level let the surrounding logic pace its writes. The serial output is a register, so it cannot glitch.

Top module: `async_tx`

## Requirements
- R1: After reset txLine is 1, fifoEmpty is 1, txEmpty is 1 and fifoLevel is 0. The line stays high whenever no character is being sent and breakOn is 0.
- R2: A frame starts with txLine low for 16 ticks. The data bits follow, least significant first, at 16 ticks each. wordLen values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and unused upper bits of wrData are not sent.
- R3: With parityEn at 1, one parity bit of 16 ticks follows the data. With parityEven at 1 the number of ones in the data and the parity bit together is even; with parityEven at 0 it is odd.
- R4: The stop period is high for 16 ticks when stopLong is 0. When stopLong is 1 it lasts 24 ticks with wordLen 0 and 32 ticks with any other wordLen.
- R5: While breakOn is 1, txLine is 0 from the next cycle on. Frame timing keeps running underneath, so after release the line shows the frame at the position it has reached.
- R6: The FIFO holds 16 characters and fifoLevel gives how many it holds. A write while fifoLevel is 16 is discarded. Characters leave in the order they were written.
- R7: txEmpty is 1 only when the FIFO is empty and no character is in the shifter. Without writes it stays 1.
- R8: Timing advances only on cycles with tick16 at 1. A character is loaded without waiting for a tick, and its start bit holds as long as no ticks arrive.
- R9: When another character is waiting, its start bit begins on the cycle right after the last stop tick, with no idle gap.
- R10: Format inputs are sampled when a character is loaded. A change while that character is being sent does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one character |
| wrData | input | DATA_W | Character to queue |
| wordLen | input | 2 | Data length: 0..3 gives 5..8 bits |
| parityEn | input | 1 | Append a parity bit |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd |
| stopLong | input | 1 | 1 selects the long stop period |
| breakOn | input | 1 | Force the line low |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| txLine | output | 1 | Serial output, high when idle |
| fifoEmpty | output | 1 | FIFO holds no character |
| txEmpty | output | 1 | FIFO and shifter both empty |
| fifoLevel | output | $clog2(FIFO_DEPTH+1) | Number of queued characters |

## Verification
A write and a FIFO pop can fall in the same cycle. With ticks held off, a burst of eighteen writes is issued. The shifter takes the first character on the same edge that the second write lands, so the level must settle at 16 and the eighteenth write must be dropped. The seventeen frames that follow are then compared bit for bit against the written order. A break can also overlap active shifting. The bench asserts it in the middle of a frame and checks that the line is low during the break and that the frame resumes at its expected position afterwards.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 8;
  localparam int LEN_W    = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } txState_e;

  typedef enum logic [1:0] {
    LINE_IDLE, LINE_START, LINE_DATA, LINE_PAR
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e sel;
  } txStrobe_t;
endpackage

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [WIDTH-1:0]               wrData,
  input  logic                           rdEn,
  output logic [WIDTH-1:0]               rdData,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [LW-1:0]    count;
  logic             full, wrOk, rdOk;

  assign full   = (count == LW'(DEPTH));
  assign empty  = (count == '0);
  assign wrOk   = wrEn && !full;
  assign rdOk   = rdEn && !empty;
  assign rdData = mem[rdPtr];
  assign level  = count;

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + AW'(1);
      if (rdOk) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + AW'(1);
      case ({wrOk, rdOk})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             fifoEmpty,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityEn,
  input  logic             stopLong,
  output txStrobe_t        strobe,
  output logic             popReq,
  output logic             busy
);
  localparam int STOP_MAX = 2 * TICKS_PER_BIT;
  localparam int CW = $clog2(STOP_MAX + 1);
  localparam int BW = $clog2(MAX_BITS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] STOP_ONE  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] STOP_HALF = CW'(TICKS_PER_BIT + TICKS_PER_BIT/2 - 1);
  localparam logic [CW-1:0] STOP_TWO  = CW'(STOP_MAX - 1);

  txState_e      state;
  logic [CW-1:0] cnt, stopLastQ, stopSel;
  logic [BW-1:0] bitIdx, lastBitQ;
  logic          parOnQ, bitEnd, stopEnd, doLoad;

  always_comb begin
    if (!stopLong)           stopSel = STOP_ONE;
    else if (wordLen == '0)  stopSel = STOP_HALF;
    else                     stopSel = STOP_TWO;
  end

  assign bitEnd  = tick16 && (cnt == BIT_LAST);
  assign stopEnd = tick16 && (cnt == stopLastQ);
  assign doLoad  = !fifoEmpty &&
                   ((state == ST_IDLE) || (state == ST_STOP && stopEnd));
  assign popReq  = doLoad;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe.load  = doLoad;
    strobe.shift = (state == ST_DATA) && bitEnd;
    case (state)
      ST_START: strobe.sel = LINE_START;
      ST_DATA:  strobe.sel = LINE_DATA;
      ST_PAR:   strobe.sel = LINE_PAR;
      default:  strobe.sel = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      lastBitQ  <= '0;
      parOnQ    <= 1'b0;
      stopLastQ <= STOP_ONE;
    end else if (doLoad) begin
      state     <= ST_START;
      cnt       <= '0;
      bitIdx    <= '0;
      lastBitQ  <= BW'(MIN_BITS - 1) + BW'(wordLen);
      parOnQ    <= parityEn;
      stopLastQ <= stopSel;
    end else begin
      case (state)
        ST_START: begin
          if (bitEnd) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else if (tick16) cnt <= cnt + CW'(1);
        end
        ST_DATA: begin
          if (bitEnd) begin
            cnt <= '0;
            if (bitIdx == lastBitQ) state <= parOnQ ? ST_PAR : ST_STOP;
            else bitIdx <= bitIdx + BW'(1);
          end else if (tick16) cnt <= cnt + CW'(1);
        end
        ST_PAR: begin
          if (bitEnd) begin
            state <= ST_STOP;
            cnt   <= '0;
          end else if (tick16) cnt <= cnt + CW'(1);
        end
        ST_STOP: begin
          if (stopEnd) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (tick16) cnt <= cnt + CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              parityEven,
  input  logic              breakOn,
  output logic              txLine
);
  logic [DATA_W-1:0] lenMask, masked, shiftQ;
  logic              parQ, parNext, lineNext, lineQ;

  for (genvar i = 0; i < DATA_W; i++) begin : gMask
    assign lenMask[i] = (i < (MIN_BITS + int'(wordLen)));
  end

  assign masked  = loadData & lenMask;
  assign parNext = parityEven ? (^masked) : ~(^masked);

  always_comb begin
    case (strobe.sel)
      LINE_START: lineNext = 1'b0;
      LINE_DATA:  lineNext = shiftQ[0];
      LINE_PAR:   lineNext = parQ;
      default:    lineNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
      lineQ  <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftQ <= masked;
        parQ   <= parNext;
      end else if (strobe.shift) begin
        shiftQ <= shiftQ >> 1;
      end
      lineQ <= breakOn ? 1'b0 : lineNext;
    end
  end

  assign txLine = lineQ;
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [LEN_W-1:0]                wordLen,
  input  logic                            parityEn,
  input  logic                            parityEven,
  input  logic                            stopLong,
  input  logic                            breakOn,
  input  logic                            tick16,
  output logic                            txLine,
  output logic                            fifoEmpty,
  output logic                            txEmpty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel
);
  txStrobe_t         strobe;
  logic              popReq, busy;
  logic [DATA_W-1:0] headData;

  async_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(popReq),
    .rdData(headData), .empty(fifoEmpty), .level(fifoLevel)
  );

  async_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .fifoEmpty(fifoEmpty),
    .wordLen(wordLen), .parityEn(parityEn), .stopLong(stopLong),
    .strobe(strobe), .popReq(popReq), .busy(busy)
  );

  async_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(headData),
    .wordLen(wordLen), .parityEven(parityEven), .breakOn(breakOn),
    .txLine(txLine)
  );

  assign txEmpty = fifoEmpty && !busy;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic                            breakOn,
  input logic                            txLine,
  input logic                            txEmpty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel
);
  localparam int LW = $clog2(FIFO_DEPTH+1);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakOn) |=> txLine);

  // R5
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |=> !txLine);

  // R7
  stay_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !wrEn) |=> txEmpty);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LW'(FIFO_DEPTH));

  // R6
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fifoLevel == $past(fifoLevel) ||
              fifoLevel == $past(fifoLevel) + LW'(1) ||
              fifoLevel == $past(fifoLevel) - LW'(1)));
endmodule

bind async_tx async_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .breakOn(breakOn),
  .txLine(txLine), .txEmpty(txEmpty), .fifoLevel(fifoLevel)
);

// File: tb/sim_async_tx.sv
module sim_async_tx;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic       parityEn = 1'b0, parityEven = 1'b0, stopLong = 1'b0;
  logic       breakOn = 1'b0, tick16 = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] wordLen = '0;
  logic       txLine, fifoEmpty, txEmpty;
  logic [4:0] fifoLevel;

  async_tx u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wordLen(wordLen),
    .parityEn(parityEn), .parityEven(parityEven), .stopLong(stopLong),
    .breakOn(breakOn), .tick16(tick16), .txLine(txLine),
    .fifoEmpty(fifoEmpty), .txEmpty(txEmpty), .fifoLevel(fifoLevel)
  );

  always #4 clk = ~clk;

  int         nChk = 0, nFail = 0;
  logic [7:0] txBuf [0:31];
  logic       expBits [0:4095];
  int         expLen;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stopTicks(input logic [1:0] wl, input logic sl);
    if (!sl) return 16;
    return (wl == 2'd0) ? 24 : 32;
  endfunction

  function automatic logic parOf(input logic [7:0] d, input logic [1:0] wl,
                                 input logic even);
    int ones = 0;
    for (int i = 0; i < 5 + int'(wl); i++) ones += int'(d[i]);
    return even ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  task automatic putBits(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      expBits[expLen] = v;
      expLen++;
    end
  endtask

  task automatic buildExp(input int n);
    expLen = 0;
    for (int c = 0; c < n; c++) begin
      putBits(1'b0, 16);
      for (int i = 0; i < 5 + int'(wordLen); i++) putBits(txBuf[c][i], 16);
      if (parityEn) putBits(parOf(txBuf[c], wordLen, parityEven), 16);
      putBits(1'b1, stopTicks(wordLen, stopLong));
    end
  endtask

  task automatic setCfg(input logic [1:0] wl, input logic pe, input logic pev,
                        input logic sl);
    @(negedge clk);
    wordLen = wl; parityEn = pe; parityEven = pev; stopLong = sl;
  endtask

  task automatic pushChars(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1;
      wrData = txBuf[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Ticks every cycle from here; compares the line sample by sample.
  task automatic checkFrames(input int n, input int brkFrom, input int brkTo,
                             input bit cfgFlip, input string req);
    int   mism = 0, firstIdx = -1, firstAct = 0, firstExp = 0;
    logic e;
    logic [1:0] wlSave = wordLen;
    logic slSave = stopLong;
    buildExp(n);
    tick16 = 1'b1;
    for (int idx = 1; idx <= expLen + 20; idx++) begin
      @(negedge clk);
      e = (idx <= expLen) ? expBits[idx-1] : 1'b1;
      if (idx >= brkFrom + 1 && idx < brkTo + 1) e = 1'b0;
      if (txLine !== e) begin
        if (mism == 0) begin
          firstIdx = idx; firstAct = int'(txLine); firstExp = int'(e);
        end
        mism++;
      end
      breakOn = (idx >= brkFrom && idx < brkTo);
      if (cfgFlip && idx == 40) begin
        wordLen = ~wordLen;
        stopLong = ~stopLong;
      end
    end
    tick16 = 1'b0;
    breakOn = 1'b0;
    wordLen = wlSave;
    stopLong = slSave;
    chk(mism == 0, req, $sformatf("serial waveform, first bad sample %0d", firstIdx),
        firstAct, firstExp);
    chk(txEmpty == 1'b1, "R7", "txEmpty after frames", int'(txEmpty), 1);
    chk(fifoLevel == 5'd0, "R6", "level after frames", int'(fifoLevel), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run not finished, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int stable;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine == 1'b1, "R1", "txLine after reset", int'(txLine), 1);
    chk(fifoEmpty == 1'b1, "R1", "fifoEmpty after reset", int'(fifoEmpty), 1);
    chk(txEmpty == 1'b1, "R1", "txEmpty after reset", int'(txEmpty), 1);
    chk(fifoLevel == 5'd0, "R1", "fifoLevel after reset", int'(fifoLevel), 0);

    // R2, R9: 8 data bits, back to back, upper-bit masking irrelevant
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    txBuf[0] = 8'hA5; txBuf[1] = 8'h3C;
    pushChars(2);
    checkFrames(2, -1, -1, 1'b0, "R2");

    // R4: 5 bits, 24-tick stop; upper bits set but not sent (R2)
    setCfg(2'd0, 1'b0, 1'b0, 1'b1);
    txBuf[0] = 8'hF5; txBuf[1] = 8'h0A;
    pushChars(2);
    checkFrames(2, -1, -1, 1'b0, "R4");

    // R3, R4: 7 bits, even parity, 32-tick stop
    setCfg(2'd2, 1'b1, 1'b1, 1'b1);
    txBuf[0] = 8'h55; txBuf[1] = 8'h7F; txBuf[2] = 8'h01;
    pushChars(3);
    checkFrames(3, -1, -1, 1'b0, "R3");

    // R3: 6 bits, odd parity
    setCfg(2'd1, 1'b1, 1'b0, 1'b0);
    txBuf[0] = 8'h00; txBuf[1] = 8'h3F; txBuf[2] = 8'h12;
    pushChars(3);
    checkFrames(3, -1, -1, 1'b0, "R3");

    // R5: break while idle
    @(negedge clk);
    breakOn = 1'b1;
    @(negedge clk);
    chk(txLine == 1'b0, "R5", "line during idle break", int'(txLine), 0);
    chk(txEmpty == 1'b1, "R5", "txEmpty during idle break", int'(txEmpty), 1);
    breakOn = 1'b0;
    @(negedge clk);
    chk(txLine == 1'b1, "R5", "line after break release", int'(txLine), 1);

    // R5: break over active shifting
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    txBuf[0] = 8'hFF;
    pushChars(1);
    checkFrames(1, 30, 60, 1'b0, "R5");

    // R10: format change mid-character has no effect on it
    setCfg(2'd3, 1'b1, 1'b1, 1'b0);
    txBuf[0] = 8'h96;
    pushChars(1);
    checkFrames(1, -1, -1, 1'b1, "R10");

    // R6, R8: fill with ticks off; write and pop coincide on the second write
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 18; i++) txBuf[i] = 8'(8'h30 + i * 7);
    pushChars(18);
    chk(fifoLevel == 5'd16, "R6", "level after 18 writes", int'(fifoLevel), 16);
    chk(fifoEmpty == 1'b0, "R6", "fifoEmpty when full", int'(fifoEmpty), 0);
    chk(txEmpty == 1'b0, "R7", "txEmpty while loaded", int'(txEmpty), 0);
    stable = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (txLine == 1'b0) stable++;
    end
    chk(stable == 40, "R8", "start bit held without ticks", stable, 40);
    checkFrames(17, -1, -1, 1'b0, "R6");

    // Random formats and data
    for (int r = 0; r < 6; r++) begin
      int n = 1 + int'($urandom % 4);
      setCfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      for (int i = 0; i < n; i++) txBuf[i] = 8'($urandom);
      pushChars(n);
      checkFrames(n, -1, -1, 1'b0, "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule